// File: doc/BRIEF.md
# Row-Accounted Transmit FIFO

This block queues outgoing bytes for a serial transmitter. A processor writes a byte, a half-word or a full word in one cycle, and each accepted write takes one storage row of four byte lanes, whatever its size. The row keeps a small code that says how many of its lanes hold data. On the serializer side the block offers one byte at a time. It starts at lane 0 of the oldest row and moves upward, and it releases the row once the last valid lane has been taken.

The occupancy flags count rows, not bytes. Four single-byte writes use half of the storage even though only four bytes are waiting, so the half-full flag reports that. The flag therefore never shows space that is not there. A five-bit status word gives empty, ready, half-full, full and a sticky overrun flag. A write to the status word with a 1 in the overrun position clears the overrun flag. A synchronous clear input empties the queue and drops every flag in one cycle.

The pop side is run by a two-state sequencer. In `DR_IDLE` no row is held. It moves to `DR_SEND` on the first accepted write. In `DR_SEND` the head row drives `pop_data`, and each accepted pop moves to the next lane. The sequencer returns to `DR_IDLE` when the last byte of the only remaining row is taken and no write arrives in that cycle. The clear input forces `DR_IDLE` from either state.

Top module: `txrow_fifo`

## Requirements
- R1: `status[0]` (empty) is 1 exactly when no row is held, and `status[1]` (ready) is 1 exactly when at least one row is held. After reset `status` is 5'b00001 and `row_count` is 0.
- R2: Every accepted write adds exactly one row to `row_count`, whether it carries 1, 2 or 4 bytes.
- R3: `wr_size` 0 stores 1 byte (`wr_data[7:0]`). `wr_size` 1 stores 2 bytes (`wr_data[15:0]`). `wr_size` 2 or 3 stores 4 bytes. Bytes leave in write order, lane 0 (`[7:0]`) first, and a row is released in the cycle its last stored byte is popped.
- R4: `status[2]` (half) is 1 exactly when 4 or more rows are held. It drops once draining takes the count below 4.
- R5: `status[3]` (full) is 1 exactly when all 8 rows are held.
- R6: A write while full is dropped, even in a cycle where a row is also freed. The next cycle `status[4]` (overrun) is 1, and it stays 1 until it is cleared.
- R7: A status write with `sts_wr_data[4]`=1 clears overrun in the next cycle, unless a dropped write happens in the same cycle. A status write with bit 4 at 0 leaves the flag as it is.
- R8: A cycle with an accepted write and a row release leaves `row_count` unchanged.
- R9: `soft_clr` wins over every other input. In the next cycle the queue is empty, `row_count` is 0, overrun is 0 and `pop_valid` is 0.
- R10: `pop_valid` is 1 exactly when at least one row is held. A pop request while it is 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_clr | input | 1 | Synchronous clear of queue and flags |
| wr_en | input | 1 | Processor write strobe |
| wr_size | input | 2 | Write width code (0 byte, 1 half, 2/3 word) |
| wr_data | input | 32 | Write data, lane 0 in bits 7:0 |
| sts_wr_en | input | 1 | Status write strobe |
| sts_wr_data | input | 5 | Status write data, bit 4 clears overrun |
| pop_req | input | 1 | Serializer takes the presented byte |
| pop_data | output | 8 | Byte at the head of the queue |
| pop_valid | output | 1 | A byte is presented |
| row_count | output | 4 | Rows held, 0 to 8 |
| status | output | 5 | {overrun, full, half, ready, empty} |

## Verification
The assertions assume that `soft_clr`, `wr_en`, `sts_wr_en` and `pop_req` are stable at the rising edge and hold no unknown values once reset is released. They also assume that `wr_size` carries one of its four codes when `wr_en` is high. The bench changes every input only on the falling edge and holds each one at a defined level at all times. It raises `pop_req` on purpose while the queue is empty, and it fills the queue to full and writes again so that overrun and its clear are exercised.

// File: rtl/txrow_pkg.sv
package txrow_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WALT = 2'd3
    } wr_size_e;

    typedef enum logic {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_state_e;

    localparam int STS_W    = 5;
    localparam int ST_EMPTY = 0;
    localparam int ST_READY = 1;
    localparam int ST_HALF  = 2;
    localparam int ST_FULL  = 3;
    localparam int ST_OVR   = 4;

endpackage

// File: rtl/txrow_store.sv
module txrow_store #(
    parameter int ROWS   = 8,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int PTR_W  = $clog2(ROWS),
    localparam int LANE_W = $clog2(LANES),
    localparam int ROW_W  = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [1:0]        wr_code,
    input  logic [PTR_W-1:0]  rd_idx,
    input  logic [LANE_W-1:0] rd_lane,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [1:0]        rd_code
);

    logic [ROW_W-1:0] row_mem  [ROWS];
    logic [1:0]       code_mem [ROWS];
    logic [ROW_W-1:0] head_row;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            row_mem[wr_idx]  <= wr_row;
            code_mem[wr_idx] <= wr_code;
        end
    end

    always_comb begin
        head_row = row_mem[rd_idx];
        rd_code  = code_mem[rd_idx];
        rd_byte  = head_row[rd_lane*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/txrow_ctrl.sv
module txrow_ctrl
    import txrow_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int PTR_W = $clog2(ROWS),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             wr_en,
    input  logic             row_free,
    input  logic             sts_wr_en,
    input  logic             sts_ovr_clr,
    output logic             push_ok,
    output logic [PTR_W-1:0] wr_idx,
    output logic [PTR_W-1:0] rd_idx,
    output logic [CNT_W-1:0] row_count,
    output logic [STS_W-1:0] status
);

    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(ROWS / 2);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ROWS);

    logic [PTR_W:0] wptr_q, rptr_q;
    logic           ovr_q;
    logic           is_full;
    logic           ovr_set;

    always_comb begin
        row_count = wptr_q - rptr_q;
        is_full   = (row_count == FULL_CNT);
        push_ok   = wr_en && !is_full;
        ovr_set   = wr_en && is_full;
        wr_idx    = wptr_q[PTR_W-1:0];
        rd_idx    = rptr_q[PTR_W-1:0];
        status    = '0;
        status[ST_EMPTY] = (row_count == '0);
        status[ST_READY] = (row_count != '0);
        status[ST_HALF]  = (row_count >= HALF_CNT);
        status[ST_FULL]  = is_full;
        status[ST_OVR]   = ovr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            ovr_q  <= 1'b0;
        end else if (soft_clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            wptr_q <= wptr_q + {{PTR_W{1'b0}}, push_ok};
            rptr_q <= rptr_q + {{PTR_W{1'b0}}, row_free};
            if (ovr_set)
                ovr_q <= 1'b1;
            else if (sts_wr_en && sts_ovr_clr)
                ovr_q <= 1'b0;
        end
    end

    // R5: occupancy never exceeds the row count
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        row_count <= FULL_CNT);

    // R2: a lone accepted write adds one row
    a_r2_one_row_per_write: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && !row_free && !soft_clr |=> row_count == $past(row_count) + 1'b1);

    // R8: add and release in one cycle cancel
    a_r8_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && row_free && !soft_clr |=> $stable(row_count));

    // R6: a dropped write raises overrun
    a_r6_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && is_full && !soft_clr |=> status[ST_OVR]);

    // R7: write-one clear takes effect
    a_r7_ovr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_en && sts_ovr_clr && !ovr_set |=> !status[ST_OVR]);

    // R9: soft clear empties everything
    a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (row_count == '0) && !status[ST_OVR]);

    // R10: no release without a held row
    a_r10_free_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
        row_free |-> row_count != '0);

endmodule

// File: rtl/txrow_drain.sv
module txrow_drain
    import txrow_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int LANES = 4,
    localparam int PTR_W  = $clog2(ROWS),
    localparam int CNT_W  = PTR_W + 1,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              push_ok,
    input  logic [CNT_W-1:0]  row_count,
    input  logic              pop_req,
    input  logic [1:0]        rd_code,
    output logic              pop_valid,
    output logic              row_free,
    output logic [LANE_W-1:0] rd_lane
);

    drain_state_e      state_q, state_d;
    logic [LANE_W-1:0] lane_q, lane_d;
    logic [LANE_W-1:0] lane_last;
    logic              fire;
    logic              last_fire;

    always_comb begin
        unique case (wr_size_e'(rd_code))
            SZ_BYTE: lane_last = '0;
            SZ_HALF: lane_last = LANE_W'(1);
            SZ_WORD: lane_last = LANE_W'(LANES - 1);
            SZ_WALT: lane_last = LANE_W'(LANES - 1);
        endcase
    end

    always_comb begin
        fire      = pop_req && (state_q == DR_SEND);
        last_fire = fire && (lane_q == lane_last);
        state_d   = state_q;
        lane_d    = lane_q;
        unique case (state_q)
            DR_IDLE: begin
                if (push_ok)
                    state_d = DR_SEND;
            end
            DR_SEND: begin
                if (last_fire && (row_count == CNT_W'(1)) && !push_ok)
                    state_d = DR_IDLE;
                if (last_fire)
                    lane_d = '0;
                else if (fire)
                    lane_d = lane_q + LANE_W'(1);
            end
        endcase
        if (soft_clr) begin
            state_d = DR_IDLE;
            lane_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            lane_q  <= lane_d;
        end
    end

    always_comb begin
        pop_valid = (state_q == DR_SEND);
        row_free  = last_fire && !soft_clr;
        rd_lane   = lane_q;
    end

    // R10: the sequencer state follows occupancy
    a_r10_valid_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid == (row_count != '0));

    // R3: lane index stays within the head row
    a_r3_lane_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> lane_q <= lane_last);

endmodule

// File: rtl/txrow_fifo.sv
module txrow_fifo
    import txrow_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    localparam int PTR_W  = $clog2(ROWS),
    localparam int CNT_W  = PTR_W + 1,
    localparam int LANE_W = $clog2(LANES),
    localparam int ROW_W  = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              wr_en,
    input  logic [1:0]        wr_size,
    input  logic [ROW_W-1:0]  wr_data,
    input  logic              sts_wr_en,
    input  logic [STS_W-1:0]  sts_wr_data,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] pop_data,
    output logic              pop_valid,
    output logic [CNT_W-1:0]  row_count,
    output logic [STS_W-1:0]  status
);

    logic              push_ok;
    logic              row_free;
    logic [PTR_W-1:0]  wr_idx, rd_idx;
    logic [LANE_W-1:0] rd_lane;
    logic [1:0]        rd_code;

    txrow_ctrl #(.ROWS(ROWS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (soft_clr),
        .wr_en       (wr_en),
        .row_free    (row_free),
        .sts_wr_en   (sts_wr_en),
        .sts_ovr_clr (sts_wr_data[ST_OVR]),
        .push_ok     (push_ok),
        .wr_idx      (wr_idx),
        .rd_idx      (rd_idx),
        .row_count   (row_count),
        .status      (status)
    );

    txrow_store #(.ROWS(ROWS), .LANES(LANES), .BYTE_W(BYTE_W)) u_store (
        .clk     (clk),
        .wr_en   (push_ok && !soft_clr),
        .wr_idx  (wr_idx),
        .wr_row  (wr_data),
        .wr_code (wr_size),
        .rd_idx  (rd_idx),
        .rd_lane (rd_lane),
        .rd_byte (pop_data),
        .rd_code (rd_code)
    );

    txrow_drain #(.ROWS(ROWS), .LANES(LANES)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .push_ok   (push_ok),
        .row_count (row_count),
        .pop_req   (pop_req),
        .rd_code   (rd_code),
        .pop_valid (pop_valid),
        .row_free  (row_free),
        .rd_lane   (rd_lane)
    );

endmodule

// File: tb/sim_txrow_fifo.sv
`timescale 1ns/1ps
module sim_txrow_fifo;

    localparam int NROWS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = 2'd0;
    logic [31:0] wr_data = '0;
    logic        sts_wr_en = 1'b0;
    logic [4:0]  sts_wr_data = '0;
    logic        pop_req = 1'b0;
    logic [7:0]  pop_data;
    logic        pop_valid;
    logic [3:0]  row_count;
    logic [4:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] b;
        bit         last;
    } item_t;
    item_t sb_q[$];
    int    m_rows = 0;
    bit    m_ovr = 1'b0;

    always #2.5 clk = ~clk;

    txrow_fifo u0 (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_en(wr_en), .wr_size(wr_size), .wr_data(wr_data),
        .sts_wr_en(sts_wr_en), .sts_wr_data(sts_wr_data),
        .pop_req(pop_req), .pop_data(pop_data), .pop_valid(pop_valid),
        .row_count(row_count), .status(status)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor and scoreboard: samples 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(int'(status[0]), int'(m_rows == 0), "R1 empty");
            chk(int'(status[1]), int'(m_rows != 0), "R1 ready");
            chk(int'(status[2]), int'(m_rows >= 4), "R4 half");
            chk(int'(status[3]), int'(m_rows == NROWS), "R5 full");
            chk(int'(status[4]), int'(m_ovr), "R6 overrun");
            chk(int'(row_count), m_rows, "R2 row count");
            chk(int'(pop_valid), int'(m_rows != 0), "R10 valid");
            if (soft_clr) begin
                sb_q.delete();
                m_rows = 0;
                m_ovr  = 1'b0;
            end else begin
                bit push_ok;
                bit freed;
                push_ok = wr_en && (m_rows < NROWS);
                freed = 1'b0;
                if (pop_req && pop_valid) begin
                    if (sb_q.size() == 0) begin
                        chk(1, 0, "R3 unexpected byte");
                    end else begin
                        chk(int'(pop_data), int'(sb_q[0].b), "R3 byte order");
                        freed = sb_q[0].last;
                        void'(sb_q.pop_front());
                    end
                end
                if (push_ok) begin
                    int nb;
                    nb = (wr_size == 2'd0) ? 1 : (wr_size == 2'd1) ? 2 : 4;
                    for (int i = 0; i < nb; i++) begin
                        item_t it;
                        it.b = wr_data[i*8 +: 8];
                        it.last = (i == nb - 1);
                        sb_q.push_back(it);
                    end
                end
                m_rows = m_rows + int'(push_ok) - int'(freed);
                if (wr_en && !push_ok)
                    m_ovr = 1'b1;
                else if (sts_wr_en && sts_wr_data[4])
                    m_ovr = 1'b0;
            end
        end
    end

    task automatic push(input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pop_n(input int n);
        @(negedge clk);
        pop_req = 1'b1;
        repeat (n) @(negedge clk);
        pop_req = 1'b0;
    endtask

    task automatic sts_write(input logic [4:0] d);
        @(negedge clk);
        sts_wr_en = 1'b1; sts_wr_data = d;
        @(negedge clk);
        sts_wr_en = 1'b0; sts_wr_data = '0;
    endtask

    task automatic settle();
        #2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk(int'(status), 5'b00001, "R1 reset status");
        chk(int'(row_count), 0, "R1 reset count");
        chk(int'(pop_valid), 0, "R10 reset valid");

        // R2 / R3: mixed sizes, one row each
        push(2'd0, 32'h000000A1);
        push(2'd1, 32'h0000B2B1);
        push(2'd2, 32'hC4C3C2C1);
        settle();
        chk(int'(row_count), 3, "R2 three rows for 7 bytes");
        pop_n(7);
        settle();
        chk(int'(row_count), 0, "R3 drained after last lane");
        chk(sb_q.size(), 0, "R3 scoreboard empty");

        // R4: four single bytes reach half
        for (int i = 0; i < 4; i++) push(2'd0, 32'h10 + i);
        settle();
        chk(int'(status[2]), 1, "R4 half at four rows");
        // R5 / R6: fill and overflow
        for (int i = 0; i < 4; i++) push(2'd3, 32'h2A2B2C00 + i);
        settle();
        chk(int'(status[3]), 1, "R5 full at eight rows");
        push(2'd0, 32'h000000EE);
        settle();
        chk(int'(status[4]), 1, "R6 overrun set");
        chk(int'(row_count), 8, "R6 write dropped");

        // R7: write zero keeps, write one clears
        sts_write(5'b01111);
        settle();
        chk(int'(status[4]), 1, "R7 zero leaves overrun");
        sts_write(5'b10000);
        settle();
        chk(int'(status[4]), 0, "R7 one clears overrun");

        // R8: free one row, then push and release together
        pop_n(1);
        @(negedge clk);
        wr_en = 1'b1; wr_size = 2'd0; wr_data = 32'h5A; pop_req = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pop_req = 1'b0;
        settle();
        chk(int'(row_count), 7, "R8 push and release hold count");

        // R4 / R10: drain, then pop into empty queue
        pop_n(40);
        settle();
        chk(int'(status[2]), 0, "R4 half drops after drain");
        chk(int'(status), 5'b00001, "R1 empty after drain");
        pop_n(3);
        settle();
        chk(int'(row_count), 0, "R10 pop while empty ignored");

        // R9: soft clear with overrun pending and data queued
        for (int i = 0; i < 9; i++) push(2'd1, 32'h00007700 + i);
        @(negedge clk);
        soft_clr = 1'b1; wr_en = 1'b1; pop_req = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0; wr_en = 1'b0; pop_req = 1'b0;
        settle();
        chk(int'(status), 5'b00001, "R9 status after clear");
        chk(int'(row_count), 0, "R9 count after clear");
        chk(int'(pop_valid), 0, "R9 valid after clear");
        push(2'd2, 32'h44332211);
        pop_n(4);
        settle();
        chk(sb_q.size(), 0, "R3 data after clear");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule